// File: doc/BRIEF.md
# PCM Time-Slot Assignment Controller

This block places one voice channel inside a serial PCM frame. It runs on the bit clock and watches two frame-sync markers, one for transmit and one for receive. It produces a serial transmit line with a per-port output enable, and it collects received bits into a byte with a one-cycle strobe. Each byte is one 8-bit time-slot, and the most significant bit goes first.

A separate mode input selects between two timings. In non-delayed timing the channel always uses the slot that begins on the cycle in which frame sync rises, and the slot number written by software is ignored. In delayed timing, bit and slot counters run from each sync, and the channel uses whichever of up to 64 slots has been assigned. The transmit and receive syncs are independent and may sit at any whole-clock offset from each other.

Software supplies, through a write strobe and a direction flag, the instruction byte that holds the slot number, a port choice and an enable. A write stops that direction at once, so that the line is never driven from a stale assignment. A separate pulse marks the end of chip-select. The new setting comes into force at the second frame sync of that direction after the pulse.

Top module: `pcm_slot_ctrl`

## Requirements
- R1: In delayed timing (mode_delayed=1), if frame sync is first seen high in cycle 0, then slot N occupies cycles 1+8N through 8+8N. The transmit line carries tx_word MSB first in those cycles, and tx_sd is 0 whenever no port is being driven.
- R2: Instruction bit 7 is the enable. When it is 0, no tx_oe bit rises and no rx_valid strobe occurs for that direction. When it is 1, the assigned slot is active.
- R3: Instruction bit 6 selects the port: 0 drives tx_oe[0] and samples rx_sd[0], and 1 drives tx_oe[1] and samples rx_sd[1]. At most one tx_oe bit is ever high. A build with one port treats bit 6 as 0.
- R4: In non-delayed timing (mode_delayed=0), the active slot is slot 0 and its first bit falls in the very cycle in which frame sync rises, whatever value instruction bits 5..0 hold.
- R5: In delayed timing, instruction bits 5..0 give the slot number in plain binary, bit 5 most significant. Transmit and receive are timed from their own syncs, whatever the offset between them.
- R6: A write to one direction (wr_dir 0 for transmit, 1 for receive) disables that direction from the next cycle onward. A transmit slot in progress stops driving, and a receive byte in progress yields no strobe.
- R7: A written assignment stays inactive through the first frame sync after the cs_end pulse and takes effect from the second.
- R8: Received bits are shifted in MSB first from the selected port. One cycle after the last bit of the slot, rx_word holds the byte and rx_valid is high for exactly one cycle.
- R9: After the last bit of slot 63, the counters stop and no further slot becomes active until the next frame sync.
- R10: After reset both directions are disabled: tx_oe is 0, tx_sd is 0 and rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_delayed | input | 1 | 0 = fixed slot at sync, 1 = counted slot assignment |
| tx_fs | input | 1 | Transmit frame-sync marker |
| rx_fs | input | 1 | Receive frame-sync marker |
| wr_valid | input | 1 | Instruction byte write strobe |
| wr_dir | input | 1 | Write target: 0 transmit, 1 receive |
| wr_data | input | 8 | Instruction byte: enable, port, slot |
| cs_end | input | 1 | End of chip-select pulse that arms pending writes |
| tx_word | input | BYTE_W | Byte to transmit, held steady during the slot |
| rx_sd | input | NPORTS | Serial receive data, one line per port |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | NPORTS | Per-port drive enable for the transmit line |
| rx_word | output | BYTE_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| tx_port | output | 1 | Port in use for transmit |
| rx_port | output | 1 | Port in use for receive |

## Verification
On every cycle, the bound checker confirms three things: the port enables stay one-hot or idle, a write silences its direction in the following cycle, and the receive strobe never lasts two cycles. It also confirms that no transmit drive appears while an assignment is still pending. Only the bench's scenarios can show the rest. That covers where each slot lands for a given slot number, mode and sync offset, and the bit order on the line. It also covers the byte assembled from the receive line, the two-frame hold-off after chip-select, the cutoff after slot 63, and the forcing of the port bit in a one-port build.

// File: rtl/pcm_slot_ctrl.sv
module pcm_slot_ctrl #(
  parameter int NPORTS = 2,
  parameter int SLOT_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_delayed,
  input  logic              tx_fs,
  input  logic              rx_fs,
  input  logic              wr_valid,
  input  logic              wr_dir,
  input  logic [7:0]        wr_data,
  input  logic              cs_end,
  input  logic [BYTE_W-1:0] tx_word,
  input  logic [NPORTS-1:0] rx_sd,
  output logic              tx_sd,
  output logic [NPORTS-1:0] tx_oe,
  output logic [BYTE_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              tx_port,
  output logic              rx_port
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int POS_W = SLOT_W + BIT_W;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [1:0] fs_raw, fs_q, fs_start;
  logic [1:0] in_slot, eff_ps;
  logic [1:0][BIT_W-1:0] bit_idx;
  logic [1:0][1:0] pend_state;

  assign fs_raw   = {rx_fs, tx_fs};
  assign fs_start = fs_raw & ~fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fs_q <= '0;
    else        fs_q <= fs_raw;
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic              wr_hit, load, erun;
    logic              act_en, act_ps, pnd_en, pnd_ps, eff_en;
    logic [SLOT_W-1:0] act_slot, pnd_slot, eff_slot, use_slot;
    logic [1:0]        pc;
    logic              run;
    logic [POS_W-1:0]  pos, epos;

    assign wr_hit = wr_valid && (wr_dir == 1'(d));
    assign load   = fs_start[d] && (pc == 2'd1) && !wr_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_en <= 1'b0; act_ps <= 1'b0; act_slot <= '0;
        pnd_en <= 1'b0; pnd_ps <= 1'b0; pnd_slot <= '0;
        pc     <= 2'd0;
      end else if (wr_hit) begin
        act_en   <= 1'b0;
        pnd_en   <= wr_data[7];
        pnd_ps   <= (NPORTS > 1) ? wr_data[6] : 1'b0;
        pnd_slot <= wr_data[SLOT_W-1:0];
        pc       <= 2'd3;
      end else begin
        if (cs_end && pc == 2'd3)
          pc <= 2'd2;
        else if (fs_start[d] && (pc == 2'd1 || pc == 2'd2))
          pc <= pc - 2'd1;
        if (load) begin
          act_en   <= pnd_en;
          act_ps   <= pnd_ps;
          act_slot <= pnd_slot;
        end
      end
    end

    assign eff_en    = load ? pnd_en   : act_en;
    assign eff_ps[d] = load ? pnd_ps   : act_ps;
    assign eff_slot  = load ? pnd_slot : act_slot;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        run <= 1'b0;
        pos <= '0;
      end else if (fs_start[d]) begin
        run <= 1'b1;
        pos <= mode_delayed ? '0 : POS_W'(1);
      end else if (run) begin
        if (pos == {POS_W{1'b1}}) run <= 1'b0;
        else                      pos <= pos + 1'b1;
      end
    end

    assign erun     = run || (fs_start[d] && !mode_delayed);
    assign epos     = (fs_start[d] && !mode_delayed) ? '0 : pos;
    assign use_slot = mode_delayed ? eff_slot : '0;
    assign in_slot[d]    = erun && eff_en && (epos[POS_W-1:BIT_W] == use_slot);
    assign bit_idx[d]    = epos[BIT_W-1:0];
    assign pend_state[d] = pc;
  end

  assign tx_sd = in_slot[0] ? tx_word[LAST_BIT - bit_idx[0]] : 1'b0;

  for (genvar p = 0; p < NPORTS; p++) begin : g_oe
    assign tx_oe[p] = in_slot[0] && (eff_ps[0] == 1'(p));
  end

  assign tx_port = eff_ps[0];
  assign rx_port = eff_ps[1];

  logic              rx_bit;
  logic [BYTE_W-1:0] rx_sh;

  assign rx_bit = (NPORTS > 1 && eff_ps[1]) ? rx_sd[NPORTS-1] : rx_sd[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (in_slot[1]) begin
        rx_sh <= {rx_sh[BYTE_W-2:0], rx_bit};
        if (bit_idx[1] == LAST_BIT && !(wr_valid && wr_dir)) begin
          rx_word  <= {rx_sh[BYTE_W-2:0], rx_bit};
          rx_valid <= 1'b1;
        end
      end
    end
  end
endmodule

module pcm_slot_ctrl_chk #(
  parameter int NPORTS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_dir,
  input logic [NPORTS-1:0] tx_oe,
  input logic              rx_valid,
  input logic [1:0]        tx_pend
);
  a_r3_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_oe));

  a_r6_tx_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_dir) |=> (tx_oe == '0));

  a_r6_rx_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_dir) |=> !rx_valid);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend == 2'd3 || tx_pend == 2'd2) |-> (tx_oe == '0));
endmodule

bind pcm_slot_ctrl pcm_slot_ctrl_chk #(.NPORTS(NPORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_dir   (wr_dir),
  .tx_oe    (tx_oe),
  .rx_valid (rx_valid),
  .tx_pend  (pend_state[0])
);

// File: tb/pcm_slot_ctrl_tb.sv
module pcm_slot_ctrl_tb;
  localparam int L = 530;
  localparam int NV = 7;
  // mode, instruction byte, tx word, rx pattern, rx phase
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h83, 8'hA5, 8'h3C, 4'd0},
    {1'b1, 8'hC0, 8'h5A, 8'hC3, 4'd5},
    {1'b1, 8'hBF, 8'hF0, 8'h81, 4'd9},
    {1'b1, 8'h4A, 8'hFF, 8'hFF, 4'd2},
    {1'b0, 8'h85, 8'h96, 8'h69, 4'd3},
    {1'b0, 8'hC0, 8'h01, 8'h80, 4'd0},
    {1'b1, 8'hE1, 8'h7E, 8'hE7, 4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_delayed = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0;
  logic wr_valid = 1'b0, wr_dir = 1'b0, cs_end = 1'b0;
  logic [7:0] wr_data = '0, tx_word = '0;
  logic [1:0] rx_sd = '0;
  logic tx_sd, rx_valid, tx_port, rx_port;
  logic [1:0] tx_oe;
  logic [7:0] rx_word;
  logic one_sd, one_valid, one_tp, one_rp;
  logic [0:0] one_oe;
  logic [7:0] one_word;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pcm_slot_ctrl u_dut (
    .clk, .rst_n, .mode_delayed, .tx_fs, .rx_fs, .wr_valid, .wr_dir, .wr_data,
    .cs_end, .tx_word, .rx_sd, .tx_sd, .tx_oe, .rx_word, .rx_valid, .tx_port, .rx_port
  );

  pcm_slot_ctrl #(.NPORTS(1)) u_one (
    .clk, .rst_n, .mode_delayed, .tx_fs, .rx_fs, .wr_valid, .wr_dir, .wr_data,
    .cs_end, .tx_word, .rx_sd(rx_sd[0:0]), .tx_sd(one_sd), .tx_oe(one_oe),
    .rx_word(one_word), .rx_valid(one_valid), .tx_port(one_tp), .rx_port(one_rp)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic dir, input logic [7:0] data);
    @(negedge clk); wr_valid = 1'b1; wr_dir = dir; wr_data = data;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic pulse_cs;
    @(negedge clk); cs_end = 1'b1;
    @(negedge clk); cs_end = 1'b0;
  endtask

  // live: assignment expected in force; kill: writes at c=20 (tx) and c=22 (rx)
  task automatic run_frame(input bit live, input bit kill, input logic [7:0] ins,
                           input logic [7:0] pat, input int ph, input string tag);
    int nval = 0;
    bit en = ins[7];
    bit ps = ins[6];
    int slot = mode_delayed ? int'(ins[5:0]) : 0;
    int st = mode_delayed ? 1 + 8 * slot : 0;
    for (int c = 0; c < L; c++) begin
      int rel = c - ph;
      bit tin;
      logic [1:0] eoe;
      logic esd;
      @(negedge clk);
      tx_fs = (c == 0);
      rx_fs = (c == ph);
      wr_valid = 1'b0;
      if (kill && c == 20) begin wr_valid = 1'b1; wr_dir = 1'b0; wr_data = ins; end
      if (kill && c == 22) begin wr_valid = 1'b1; wr_dir = 1'b1; wr_data = ins; end
      if (rel >= st && rel < st + 8) begin
        rx_sd[ps]  = pat[7 - (rel - st)];
        rx_sd[!ps] = ~pat[7 - (rel - st)];
      end else rx_sd = {c[0], ~c[0]};
      #1;
      tin = live && en && c >= st && c < st + 8 && !(kill && c > 20);
      eoe = tin ? (ps ? 2'b10 : 2'b01) : 2'b00;
      esd = tin ? tx_word[7 - (c - st)] : 1'b0;
      chk(tx_oe == eoe, {tag, " R1 R2 R3 R6 R7 R9 tx_oe"}, 16'(tx_oe), 16'(eoe));
      chk(tx_sd == esd, {tag, " R1 R4 R5 tx_sd"}, 16'(tx_sd), 16'(esd));
      chk(one_oe[0] == tin, {tag, " R3 single-port oe"}, 16'(one_oe), 16'(tin));
      if (rx_valid) begin
        nval++;
        chk(rel == st + 8, {tag, " R8 strobe timing"}, 16'(rel), 16'(st + 8));
        chk(rx_word == pat, {tag, " R8 rx_word"}, 16'(rx_word), 16'(pat));
      end
    end
    wr_valid = 1'b0;
    chk(nval == ((live && en && !kill) ? 1 : 0), {tag, " R2 R6 R7 R8 strobe count"},
        16'(nval), 16'((live && en && !kill) ? 1 : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(tx_oe == 2'b00, "R10 reset tx_oe", 16'(tx_oe), 16'h0);
    chk(tx_sd == 1'b0, "R10 reset tx_sd", 16'(tx_sd), 16'h0);
    chk(rx_valid == 1'b0, "R10 reset rx_valid", 16'(rx_valid), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    mode_delayed = 1'b1; tx_word = 8'hA5;
    run_frame(1'b0, 1'b0, 8'h83, 8'h3C, 0, "R10 post-reset frame");

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e = VEC[v];
      @(negedge clk);
      mode_delayed = e[28]; tx_word = e[19:12];
      wr(1'b0, e[27:20]);
      wr(1'b1, e[27:20]);
      pulse_cs();
      run_frame(1'b0, 1'b0, e[27:20], e[11:4], int'(e[3:0]), "R7 first frame");
      run_frame(1'b1, 1'b0, e[27:20], e[11:4], int'(e[3:0]), "R5 second frame");
      run_frame(1'b1, 1'b0, e[27:20], e[11:4], int'(e[3:0]), "R9 third frame");
    end

    // directed: write during an active slot
    @(negedge clk);
    mode_delayed = 1'b1; tx_word = 8'h3B;
    wr(1'b0, 8'h82); wr(1'b1, 8'h82); pulse_cs();
    run_frame(1'b0, 1'b0, 8'h82, 8'hD2, 0, "R7 kill setup");
    run_frame(1'b1, 1'b0, 8'h82, 8'hD2, 0, "R1 kill setup");
    run_frame(1'b1, 1'b1, 8'h82, 8'hD2, 0, "R6 mid-slot write");
    run_frame(1'b0, 1'b0, 8'h82, 8'hD2, 0, "R6 R7 after kill");
    pulse_cs();
    run_frame(1'b0, 1'b0, 8'h82, 8'hD2, 0, "R7 rearm first");
    run_frame(1'b1, 1'b0, 8'h82, 8'hD2, 0, "R7 rearm second");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule